// File: doc/BRIEF.md
# Slow Oscillator Trim Calibrator

This block tunes the 4-bit trim code of a slow on-chip oscillator against a fast, trusted reference clock. It runs entirely in the reference domain. The slow oscillator output is brought in through a two-flop synchronizer, and its rising edges are detected there. Each edge copies a free-running 16-bit reference timer into a capture register. The gap between two successive captures is the oscillator period, counted in reference ticks.

After a start pulse, the trim code is reloaded from the factory value. The loop then measures one clean period and compares it with a programmable window. It moves the code by exactly one LSB toward the window. A lower code makes the oscillator faster, so a period that is too long decrements the code and one that is too short increments it. The step size of the trim code is unknown and nonlinear, so every step is followed by a fresh measurement. The capture that follows a change is thrown away, so no period that spans a change is ever judged.

The loop ends with a done flag when the period lands inside the window. It ends with a fail flag on any of three conditions:
- a required step would go past a code limit;
- the adjustment budget is spent;
- the oscillator stops toggling.

Top module: `lfo_trim_cal`

## Requirements
- R1: While `rst_n` is low, `trimCode` takes `trimInit`, `periodOut` is 0, and `done` and `fail` are 0.
- R2: A `startPulse` reloads `trimCode` from `trimInit`, clears `done`, `fail` and the adjustment count, and begins a new measurement. It takes priority over an oscillator edge or a timeout in the same cycle.
- R3: The first synchronized rising edge after a start or after any trim change only records a capture. No period is reported and no decision is taken until the next edge.
- R4: On a measuring edge, `periodOut` takes the 16-bit modulo difference between the timer values captured at this edge and at the previous edge. This holds correctly across timer wraparound. `periodOut` changes on no other cycle.
- R5: A measured period greater than `periodHi` decrements `trimCode` by one.
- R6: A measured period less than `periodLo` increments `trimCode` by one.
- R7: A period with `periodLo` <= period <= `periodHi` raises `done` and leaves `trimCode` unchanged.
- R8: A step below 0 or above 15 is never taken. `trimCode` stays at the limit and `fail` rises instead.
- R9: Once 16 adjustments have been made since the start, a further required adjustment raises `fail` and leaves `trimCode` unchanged.
- R10: If no synchronized edge arrives for TIMEOUT consecutive reference cycles while measuring, `fail` rises. An edge in the expiry cycle wins over the timeout.
- R11: `done` and `fail` are never both high. Both, and `trimCode`, hold their values until the next `startPulse`, whatever the oscillator does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, the known timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| oscIn | input | 1 | Slow oscillator output, asynchronous to clk |
| startPulse | input | 1 | One-cycle request to begin calibration |
| trimInit | input | 4 | Factory trim value loaded at reset and start |
| periodLo | input | 16 | Lower bound of the target period, in reference ticks |
| periodHi | input | 16 | Upper bound of the target period, in reference ticks |
| trimCode | output | 4 | Trim code driven to the oscillator |
| periodOut | output | 16 | Last measured period, in reference ticks |
| done | output | 1 | Period is inside the window; calibration finished |
| fail | output | 1 | Limit, adjustment budget or timeout reached |

## Verification
Two collisions can fall in the same cycle. The first is a start request against a synchronized oscillator edge. The bench provokes it by watching the oscillator's rise and timing the start so that it is sampled in the cycle where the edge reaches the detector. The result is judged by the reference model: the trim code must be the reloaded factory value, no period may be latched, and the next edge must only arm the loop. The second is timeout expiry against a late edge, which the same per-cycle model comparison covers. Timer wraparound is forced by delaying one calibration until the free-running count is about to roll over.

// File: rtl/lfo_trim_pkg.sv
package lfo_trim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_DONE,
    ST_FAIL
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTrim;
    logic incTrim;
    logic decTrim;
    logic latchPeriod;
    logic clrTimeout;
    logic runTimeout;
  } dpCtrl_t;

endpackage

// File: rtl/lfo_trim_sync.sv
module lfo_trim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic asyncIn,
  output logic riseEdge
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= asyncIn;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign riseEdge = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/lfo_trim_datapath.sv
module lfo_trim_datapath
  import lfo_trim_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int TRIM_W  = 4,
  parameter int TIMEOUT = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oscEdge,
  input  dpCtrl_t            ctl,
  input  logic [TRIM_W-1:0]  trimInit,
  input  logic [TIMER_W-1:0] periodLo,
  input  logic [TIMER_W-1:0] periodHi,
  output logic [TRIM_W-1:0]  trimCode,
  output logic [TIMER_W-1:0] periodOut,
  output logic               aboveHi,
  output logic               belowLo,
  output logic               atMin,
  output logic               atMax,
  output logic               timeoutHit
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [TIMER_W-1:0] timerQ, capQ, periodQ, periodNow;
  logic [TRIM_W-1:0]  trimQ;
  logic [CNT_W-1:0]   toCnt;

  // free-running reference timebase
  always_ff @(posedge clk) begin
    if (!rst_n) timerQ <= '0;
    else        timerQ <= timerQ + TIMER_W'(1);
  end

  // every edge copies the timer
  always_ff @(posedge clk) begin
    if (!rst_n)       capQ <= '0;
    else if (oscEdge) capQ <= timerQ;
  end

  // modulo subtraction absorbs wraparound
  assign periodNow = timerQ - capQ;
  assign aboveHi   = periodNow > periodHi;
  assign belowLo   = periodNow < periodLo;

  always_ff @(posedge clk) begin
    if (!rst_n)               periodQ <= '0;
    else if (ctl.latchPeriod) periodQ <= periodNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            trimQ <= trimInit;
    else if (ctl.loadTrim) trimQ <= trimInit;
    else if (ctl.incTrim)  trimQ <= trimQ + TRIM_W'(1);
    else if (ctl.decTrim)  trimQ <= trimQ - TRIM_W'(1);
  end

  assign atMin = (trimQ == '0);
  assign atMax = (trimQ == '1);

  // cycles since the last edge
  always_ff @(posedge clk) begin
    if (!rst_n)                         toCnt <= '0;
    else if (ctl.clrTimeout || oscEdge) toCnt <= '0;
    else if (ctl.runTimeout)            toCnt <= toCnt + CNT_W'(1);
  end

  assign timeoutHit = (toCnt == CNT_W'(TIMEOUT - 1));
  assign trimCode   = trimQ;
  assign periodOut  = periodQ;

endmodule

// File: rtl/lfo_trim_ctrl.sv
module lfo_trim_ctrl
  import lfo_trim_pkg::*;
#(
  parameter int MAX_ADJ = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startPulse,
  input  logic    oscEdge,
  input  logic    aboveHi,
  input  logic    belowLo,
  input  logic    atMin,
  input  logic    atMax,
  input  logic    timeoutHit,
  output dpCtrl_t ctl,
  output logic    done,
  output logic    fail
);
  localparam int ITER_W = $clog2(MAX_ADJ + 1);

  calState_t         state, stateNext;
  logic [ITER_W-1:0] iterQ, iterNext;
  logic              budgetOut;

  assign budgetOut = (iterQ == ITER_W'(MAX_ADJ));

  always_comb begin
    ctl       = '0;
    stateNext = state;
    iterNext  = iterQ;
    if (startPulse) begin
      ctl.loadTrim   = 1'b1;
      ctl.clrTimeout = 1'b1;
      iterNext       = '0;
      stateNext      = ST_ARM;
    end else begin
      unique case (state)
        ST_ARM: begin
          ctl.runTimeout = 1'b1;
          if (oscEdge)         stateNext = ST_MEAS;
          else if (timeoutHit) stateNext = ST_FAIL;
        end
        ST_MEAS: begin
          ctl.runTimeout = 1'b1;
          if (oscEdge) begin
            ctl.latchPeriod = 1'b1;
            if (aboveHi) begin
              if (atMin || budgetOut) stateNext = ST_FAIL;
              else begin
                ctl.decTrim = 1'b1;
                iterNext    = iterQ + ITER_W'(1);
                stateNext   = ST_ARM;
              end
            end else if (belowLo) begin
              if (atMax || budgetOut) stateNext = ST_FAIL;
              else begin
                ctl.incTrim = 1'b1;
                iterNext    = iterQ + ITER_W'(1);
                stateNext   = ST_ARM;
              end
            end else begin
              stateNext = ST_DONE;
            end
          end else if (timeoutHit) begin
            stateNext = ST_FAIL;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      iterQ <= '0;
    end else begin
      state <= stateNext;
      iterQ <= iterNext;
    end
  end

  assign done = (state == ST_DONE);
  assign fail = (state == ST_FAIL);

endmodule

// File: rtl/lfo_trim_cal.sv
module lfo_trim_cal
  import lfo_trim_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int TRIM_W      = 4,
  parameter int TIMEOUT     = 1024,
  parameter int MAX_ADJ     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oscIn,
  input  logic               startPulse,
  input  logic [TRIM_W-1:0]  trimInit,
  input  logic [TIMER_W-1:0] periodLo,
  input  logic [TIMER_W-1:0] periodHi,
  output logic [TRIM_W-1:0]  trimCode,
  output logic [TIMER_W-1:0] periodOut,
  output logic               done,
  output logic               fail
);
  logic    oscEdge;
  dpCtrl_t ctl;
  logic    aboveHi, belowLo, atMin, atMax, timeoutHit;

  lfo_trim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(oscIn), .riseEdge(oscEdge)
  );

  lfo_trim_datapath #(.TIMER_W(TIMER_W), .TRIM_W(TRIM_W), .TIMEOUT(TIMEOUT)) u_dp (
    .clk(clk), .rst_n(rst_n), .oscEdge(oscEdge), .ctl(ctl),
    .trimInit(trimInit), .periodLo(periodLo), .periodHi(periodHi),
    .trimCode(trimCode), .periodOut(periodOut),
    .aboveHi(aboveHi), .belowLo(belowLo), .atMin(atMin), .atMax(atMax),
    .timeoutHit(timeoutHit)
  );

  lfo_trim_ctrl #(.MAX_ADJ(MAX_ADJ)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .oscEdge(oscEdge),
    .aboveHi(aboveHi), .belowLo(belowLo), .atMin(atMin), .atMax(atMax),
    .timeoutHit(timeoutHit), .ctl(ctl), .done(done), .fail(fail)
  );

endmodule

// File: rtl/lfo_trim_cal_checker.sv
module lfo_trim_cal_checker #(
  parameter int TIMER_W = 16,
  parameter int TRIM_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               startPulse,
  input logic [TRIM_W-1:0]  trimInit,
  input logic [TRIM_W-1:0]  trimCode,
  input logic [TIMER_W-1:0] periodOut,
  input logic               done,
  input logic               fail,
  input logic               oscEdge
);

  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !startPulse) |=> (done && $stable(trimCode)));

  p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !startPulse) |=> (fail && $stable(trimCode)));

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (trimCode == $past(trimInit) && !done && !fail));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !startPulse |=> (trimCode == $past(trimCode) ||
                     trimCode == TRIM_W'($past(trimCode) + TRIM_W'(1)) ||
                     trimCode == TRIM_W'($past(trimCode) - TRIM_W'(1))));

  p_period_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oscEdge |=> $stable(periodOut));

  p_trim_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!oscEdge && !startPulse) |=> $stable(trimCode));

endmodule

bind lfo_trim_cal lfo_trim_cal_checker #(.TIMER_W(TIMER_W), .TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .trimInit(trimInit),
  .trimCode(trimCode), .periodOut(periodOut), .done(done), .fail(fail),
  .oscEdge(oscEdge)
);

// File: tb/lfo_trim_cal_bench.sv
module lfo_trim_cal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BENCH_TO   = 1024;
  localparam int BUDGET     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oscIn = 1'b0;
  logic        startPulse = 1'b0;
  logic [3:0]  trimInit = 4'd8;
  logic [15:0] periodLo = 16'd0;
  logic [15:0] periodHi = 16'hFFFF;
  logic [3:0]  trimCode;
  logic [15:0] periodOut;
  logic        done, fail;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit modelLive = 0;
  bit oscRun = 0;
  bit oscRose = 0;
  int oscPhase = 0;

  // reference model state
  bit mQ1, mQ2, mQ3;
  int mTimer, mCap, mPeriod, mCnt, mIter, mTrim, mState; // 0 idle 1 arm 2 meas 3 done 4 fail

  lfo_trim_cal #(.TIMEOUT(BENCH_TO), .MAX_ADJ(BUDGET)) u_lfo_trim_cal (
    .clk(clk), .rst_n(rst_n), .oscIn(oscIn), .startPulse(startPulse),
    .trimInit(trimInit), .periodLo(periodLo), .periodHi(periodHi),
    .trimCode(trimCode), .periodOut(periodOut), .done(done), .fail(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow oscillator: monotonic, nonlinear period in reference cycles
  function automatic int oscPeriod(int t);
    return 40 + 2*t + (t*t)/3;
  endfunction

  always @(negedge clk) begin
    oscRose = 0;
    if (oscRun) begin
      if (oscPhase + 1 >= oscPeriod(int'(trimCode))) begin
        oscPhase = 0;
        oscRose  = 1;
      end else oscPhase = oscPhase + 1;
      oscIn = (oscPhase < oscPeriod(int'(trimCode)) / 2);
    end else oscIn = 1'b0;
  end

  always @(posedge clk) begin
    bit e, hit;
    int pnow, nState;
    cycles++;
    if (!rst_n) begin
      mQ1 = 0; mQ2 = 0; mQ3 = 0; mTimer = 0; mCap = 0; mPeriod = 0;
      mCnt = 0; mIter = 0; mTrim = int'(trimInit); mState = 0;
    end else begin
      e      = mQ2 && !mQ3;
      pnow   = (mTimer - mCap + 65536) % 65536;
      hit    = (mCnt == BENCH_TO - 1);
      nState = mState;
      if (startPulse) begin
        mTrim = int'(trimInit); mIter = 0; nState = 1;
      end else if (mState == 1) begin
        if (e) nState = 2; else if (hit) nState = 4;
      end else if (mState == 2) begin
        if (e) begin
          mPeriod = pnow;
          if (pnow > int'(periodHi)) begin
            if (mTrim == 0 || mIter == BUDGET) nState = 4;
            else begin mTrim--; mIter++; nState = 1; end
          end else if (pnow < int'(periodLo)) begin
            if (mTrim == 15 || mIter == BUDGET) nState = 4;
            else begin mTrim++; mIter++; nState = 1; end
          end else nState = 3;
        end else if (hit) nState = 4;
      end
      if (startPulse || e) mCnt = 0;
      else if (mState == 1 || mState == 2) mCnt++;
      if (e) mCap = mTimer;
      mTimer = (mTimer + 1) % 65536;
      mQ3 = mQ2; mQ2 = mQ1; mQ1 = oscIn;
      mState = nState;
    end
    modelLive = 1;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (modelLive) begin
      check(int'(trimCode) == mTrim, "R5/R6 trimCode vs model", int'(trimCode), mTrim);
      check(int'(periodOut) == mPeriod, "R4 periodOut vs model", int'(periodOut), mPeriod);
      check(done == (mState == 3), "R7 done vs model", int'(done), int'(mState == 3));
      check(fail == (mState == 4), "R8 fail vs model", int'(fail), int'(mState == 4));
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done || fail) break;
    end
  endtask

  task automatic runCal(int init, int lo, int hi);
    @(negedge clk);
    trimInit = 4'(init); periodLo = 16'(lo); periodHi = 16'(hi);
    pulseStart();
    waitEnd();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(trimCode == 4'd8, "R1 trim at reset", int'(trimCode), 8);
    check(periodOut == 16'd0 && !done && !fail, "R1 outputs at reset", int'(periodOut), 0);
    @(negedge clk) rst_n = 1'b1;
    oscRun = 1;
    repeat (300) @(negedge clk);
    check(trimCode == 4'd8 && !done && !fail, "R2 idle before start", int'(trimCode), 8);

    // R5 decrement toward window
    runCal(8, 55, 60);
    check(done == 1'b1, "R5/R7 done after decrements", int'(done), 1);
    check(trimCode == 4'd5, "R5 trim converged", int'(trimCode), 5);
    check(int'(periodOut) == oscPeriod(5), "R4 period at code 5", int'(periodOut), oscPeriod(5));

    // R11 hold while oscillator keeps running
    repeat (500) @(negedge clk);
    check(done && !fail && trimCode == 4'd5, "R11 done holds", int'(trimCode), 5);

    // R6 increment toward window
    runCal(2, 100, 105);
    check(done == 1'b1, "R6/R7 done after increments", int'(done), 1);
    check(trimCode == 4'd11, "R6 trim converged", int'(trimCode), 11);

    // R8 saturation low and high
    runCal(3, 30, 35);
    check(fail == 1'b1 && trimCode == 4'd0, "R8 saturate at zero", int'(trimCode), 0);
    repeat (300) @(negedge clk);
    check(fail && !done && trimCode == 4'd0, "R11 fail holds", int'(trimCode), 0);
    runCal(12, 150, 160);
    check(fail == 1'b1 && trimCode == 4'd15, "R8 saturate at fifteen", int'(trimCode), 15);

    // R9 window between two codes: bounce until budget is spent
    runCal(6, 65, 69);
    check(fail == 1'b1, "R9 budget fail", int'(fail), 1);
    check(trimCode == 4'd6, "R9 trim after even bounces", int'(trimCode), 6);

    // R2 start collides with a synchronized edge
    trimInit = 4'd8; periodLo = 16'd55; periodHi = 16'd60;
    do @(posedge clk); while (!oscRose);
    @(negedge clk); @(posedge clk);
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
    check(trimCode == 4'd8 && !done && !fail, "R2 start over edge", int'(trimCode), 8);
    waitEnd();
    check(done && trimCode == 4'd5, "R3 converge after collision", int'(trimCode), 5);

    // R4 wraparound of the timebase during measurement
    while (mTimer != 65400) @(negedge clk);
    runCal(8, 55, 60);
    check(done && int'(periodOut) == oscPeriod(5), "R4 wrap period", int'(periodOut), oscPeriod(5));

    // R10 timeout with a stopped oscillator
    oscRun = 0;
    repeat (10) @(negedge clk);
    trimInit = 4'd7;
    pulseStart();
    repeat (BENCH_TO - 30) @(negedge clk);
    check(!fail, "R10 no early timeout", int'(fail), 0);
    repeat (60) @(negedge clk);
    check(fail && trimCode == 4'd7, "R10 timeout fail", int'(fail), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule